// File: doc/BRIEF.md
# Coherent Cache Miss Fill Controller

This block holds the per-line coherence state and the miss handling of a small private direct-mapped cache using the four MESI states. A read that misses takes a free fill buffer and sends one line request to memory. The array entry for that line stays Invalid while the data is outstanding. The waiting condition lives only in the fill buffer. Reads to other resident lines keep hitting in the meantime, and further reads to the pending line join the same buffer without a new memory request.

When the memory returns the line, the array entry is written with Exclusive, or with Shared if memory reports another holder. Every requester that joined the buffer then gets the data, one per cycle, in the order in which it joined. Snoops from other caches are served at all times from the state the array holds in that cycle. Two event counters track primary misses and reads that joined an existing fill.

Top module: `cfc_fill_ctrl`

## Requirements
- R1: After reset every line is Invalid, both counters read zero, every valid output is low and `req_ready` is high.
- R2: A read that finds its line in S, E or M returns `hr_valid` with the line data, the request id and `hr_err`=0 on the cycle after acceptance.
- R3: A read miss with no pending fill for that line takes the lowest-numbered idle fill buffer and raises `mem_req_valid` for one cycle with the full line address and that buffer number. `miss_cnt` increments. The line still reads as Invalid to writes and snoops until the fill arrives.
- R4: A fill writes the line with Exclusive when `mem_fill_shared`=0 and with Shared when it is 1, and stores the fill data. A fill that names a buffer that is not waiting is ignored.
- R5: A read miss to a line whose fill is still outstanding joins that buffer. It issues no memory request and increments `merge_cnt`.
- R6: After the cycle in which a fill is taken, every requester attached to that buffer is returned on `fr_valid`/`fr_id`/`fr_data`, one per consecutive cycle, in attach order, primary requester first. When more than one buffer is draining, the lowest-numbered one goes first.
- R7: While a miss is outstanding, reads to other resident lines hit with the latency of R2.
- R8: A read miss to a new line when no buffer is idle, or a read that would join a buffer already holding 4 requesters, sees `req_ready` low and causes no memory request and no counter change.
- R9: A snoop gets `sr_valid` on the next cycle. A snoop to a valid matching line reports `sr_hit`=1. A read snoop leaves the line Shared; an invalidating snoop (`snp_inv`=1) leaves it Invalid. `sr_dirty`=1 and `sr_data` carry the line only when the line was Modified. A line whose fill is pending answers `sr_hit`=0.
- R10: A write to a line in E or M stores the data, sets Modified and acknowledges with `hr_err`=0 and the written data. A write to a line in S, in I or pending returns `hr_err`=1 and changes nothing.
- R11: In a cycle where a fill is written to the index of the request, or a snoop targets that index, `req_ready` is low.
- R12: A fill that replaces a Modified line raises `wb_valid` on the next cycle with the old line address and data. It does not do so if the old line was not Modified, or if a snoop to that old line in the same cycle already took it.
- R13: A snoop in the same cycle as a fill to the same index is answered from the state held before the fill. The filled line is resident afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Line address; low log2(NL) bits are the index |
| req_id | input | IDW | Requester id |
| req_wdata | input | DW | Write data |
| hr_valid | output | 1 | Hit or write response |
| hr_id | output | IDW | Id of the response |
| hr_data | output | DW | Read data or written data |
| hr_err | output | 1 | Write refused |
| fr_valid | output | 1 | Fill delivery to one attached requester |
| fr_id | output | IDW | Id of that requester |
| fr_data | output | DW | Filled line data |
| mem_req_valid | output | 1 | Line request to memory (one cycle) |
| mem_req_line | output | AW | Requested line address |
| mem_req_buf | output | BW | Fill buffer that will take the reply |
| mem_fill_valid | input | 1 | Memory reply present |
| mem_fill_buf | input | BW | Buffer the reply belongs to |
| mem_fill_data | input | DW | Reply data |
| mem_fill_shared | input | 1 | Another cache holds the line |
| snp_valid | input | 1 | Snoop present |
| snp_addr | input | AW | Snooped line address |
| snp_inv | input | 1 | 1 = invalidating snoop, 0 = read snoop |
| sr_valid | output | 1 | Snoop answer |
| sr_hit | output | 1 | A valid copy was held |
| sr_dirty | output | 1 | The copy was Modified |
| sr_data | output | DW | Modified data, else zero |
| wb_valid | output | 1 | Modified victim written back |
| wb_line | output | AW | Victim line address |
| wb_data | output | DW | Victim data |
| miss_cnt | output | CW | Primary misses issued |
| merge_cnt | output | CW | Reads that joined an outstanding fill |

## Verification
The two functions that can land in the same cycle are a fill being written into the array and another agent working on the same index. That agent may be a core request or a snoop. The bench drives a memory reply together with a request to the victim line and expects `req_ready` low, then a write-back of the old Modified data on the next cycle. It also drives a reply together with a read snoop or an invalidating snoop to the line being replaced. The snoop answer must reflect the old state and dirtiness, the write-back must be suppressed when the snoop took the dirty data, and a later snoop must show the filled line as resident.

// File: rtl/cfc_pkg.sv
// Shared types of the coherent miss fill controller.
// Assumes: one coherence state per line, one state per fill buffer.
package cfc_pkg;
    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        FB_IDLE  = 2'd0,
        FB_WAIT  = 2'd1,
        FB_DRAIN = 2'd2
    } fb_st_t;
endpackage

// File: rtl/cfc_tag_array.sv
// Tag, state and data store of a direct-mapped cache, with snoop handling.
// Does: combinational lookup, write hits, snoop answers, fill installs with
// victim write-back. Assumes: the caller never writes and snoops the same
// index in one cycle, and never writes and installs the same index.
// A snoop and an install to one index apply in that order.
module cfc_tag_array
    import cfc_pkg::*;
#(
    parameter int NL = 8,
    parameter int TW = 5,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [$clog2(NL)-1:0] lk_idx,
    output line_st_t              lk_st,
    output logic [TW-1:0]         lk_tag,
    output logic [DW-1:0]         lk_data,
    input  logic                  wr_en,
    input  logic [$clog2(NL)-1:0] wr_idx,
    input  logic [DW-1:0]         wr_data,
    input  logic                  snp_en,
    input  logic [$clog2(NL)-1:0] snp_idx,
    input  logic [TW-1:0]         snp_tag,
    input  logic                  snp_inv,
    output logic                  sr_valid,
    output logic                  sr_hit,
    output logic                  sr_dirty,
    output logic [DW-1:0]         sr_data,
    input  logic                  ins_en,
    input  logic [$clog2(NL)-1:0] ins_idx,
    input  logic [TW-1:0]         ins_tag,
    input  logic [DW-1:0]         ins_data,
    input  logic                  ins_shared,
    output logic                  wb_valid,
    output logic [TW+$clog2(NL)-1:0] wb_line,
    output logic [DW-1:0]         wb_data
);
    localparam int IW = $clog2(NL);

    line_st_t      st [NL];
    logic [TW-1:0] tg [NL];
    logic [DW-1:0] dt [NL];
    logic          snp_match;

    // Lookup port for the request path.
    assign lk_st   = st[lk_idx];
    assign lk_tag  = tg[lk_idx];
    assign lk_data = dt[lk_idx];

    // A snoop touches the array only for a valid line with matching tag.
    assign snp_match = snp_en && (st[snp_idx] != LN_I) && (tg[snp_idx] == snp_tag);

    // Array update: write hit, then snoop effect, then install (last wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) st[i] <= LN_I;
        end else begin
            if (wr_en) begin
                st[wr_idx] <= LN_M;
                dt[wr_idx] <= wr_data;
            end
            if (snp_match) st[snp_idx] <= snp_inv ? LN_I : LN_S;
            if (ins_en) begin
                st[ins_idx] <= ins_shared ? LN_S : LN_E;
                tg[ins_idx] <= ins_tag;
                dt[ins_idx] <= ins_data;
            end
        end
    end

    // Registered snoop answer and victim write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_valid <= 1'b0;
            sr_hit   <= 1'b0;
            sr_dirty <= 1'b0;
            sr_data  <= '0;
            wb_valid <= 1'b0;
            wb_line  <= '0;
            wb_data  <= '0;
        end else begin
            sr_valid <= snp_en;
            sr_hit   <= snp_match;
            sr_dirty <= snp_match && (st[snp_idx] == LN_M);
            sr_data  <= (snp_match && (st[snp_idx] == LN_M)) ? dt[snp_idx] : '0;
            wb_valid <= ins_en && (st[ins_idx] == LN_M)
                        && !(snp_match && (snp_idx == ins_idx));
            wb_line  <= {tg[ins_idx], ins_idx};
            wb_data  <= dt[ins_idx];
        end
    end

    // R10
    write_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st[wr_idx] == LN_E || st[wr_idx] == LN_M));

    // R4
    install_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> (st[$past(ins_idx)] == ($past(ins_shared) ? LN_S : LN_E)));

    // R9
    snoop_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_match && snp_inv && !(ins_en && ins_idx == snp_idx))
        |=> (st[$past(snp_idx)] == LN_I));

    logic unused_ok;
    assign unused_ok = ^{IW};
endmodule

// File: rtl/cfc_fill_buf.sv
// One line-fill buffer: holds the transient wait-for-data state of a miss,
// the ordered list of attached requesters, and the fill data while it
// hands the data to them one per pop. Assumes MQ >= 2 and that the caller
// never merges into a full buffer.
module cfc_fill_buf
    import cfc_pkg::*;
#(
    parameter int LW  = 8,
    parameter int IDW = 4,
    parameter int DW  = 16,
    parameter int MQ  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc,
    input  logic [LW-1:0]  alloc_line,
    input  logic [IDW-1:0] alloc_id,
    input  logic           merge,
    input  logic [IDW-1:0] merge_id,
    input  logic           fill,
    input  logic [DW-1:0]  fill_data,
    input  logic           pop,
    output fb_st_t         fb_st,
    output logic [LW-1:0]  fb_line,
    output logic           full,
    output logic [IDW-1:0] head_id,
    output logic [DW-1:0]  fb_data
);
    localparam int QW = $clog2(MQ + 1);
    localparam int PW = $clog2(MQ);

    fb_st_t         st_q;
    logic [LW-1:0]  line_q;
    logic [IDW-1:0] ids [MQ];
    logic [QW-1:0]  cnt;
    logic [PW-1:0]  rd;
    logic [DW-1:0]  data_q;

    // Buffer state machine: idle -> wait for data -> drain -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FB_IDLE;
            cnt  <= '0;
            rd   <= '0;
        end else begin
            case (st_q)
                FB_IDLE: if (alloc) begin
                    st_q   <= FB_WAIT;
                    line_q <= alloc_line;
                    ids[0] <= alloc_id;
                    cnt    <= QW'(1);
                    rd     <= '0;
                end
                FB_WAIT: begin
                    if (merge) begin
                        ids[cnt[PW-1:0]] <= merge_id;
                        cnt              <= cnt + QW'(1);
                    end
                    if (fill) begin
                        st_q   <= FB_DRAIN;
                        data_q <= fill_data;
                    end
                end
                FB_DRAIN: if (pop) begin
                    if (QW'(rd) + QW'(1) == cnt) st_q <= FB_IDLE;
                    else                         rd   <= rd + PW'(1);
                end
                default: st_q <= FB_IDLE;
            endcase
        end
    end

    assign fb_st   = st_q;
    assign fb_line = line_q;
    assign full    = (cnt == QW'(MQ));
    assign head_id = ids[rd];
    assign fb_data = data_q;

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FB_WAIT && !fill) |=> (st_q == FB_WAIT && $stable(line_q)));
endmodule

// File: rtl/cfc_fill_ctrl.sv
// Coherent miss fill controller (top). Looks up each core request in the
// tag array. Hits answer the next cycle. Read misses either join a waiting
// fill buffer with the same line or take the lowest idle buffer and issue a
// memory request. Memory replies install the line and drain the attached
// requesters in order. Snoops are served from the array every cycle.
// Assumes: memory always accepts a request; the fabric orders a snoop that
// coincides with a fill before that fill.
module cfc_fill_ctrl
    import cfc_pkg::*;
#(
    parameter int AW  = 8,
    parameter int NL  = 8,
    parameter int IDW = 4,
    parameter int DW  = 16,
    parameter int NFB = 2,
    parameter int MQ  = 4,
    parameter int CW  = 16,
    localparam int BW = (NFB > 1) ? $clog2(NFB) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_wr,
    input  logic [AW-1:0]  req_addr,
    input  logic [IDW-1:0] req_id,
    input  logic [DW-1:0]  req_wdata,
    output logic           hr_valid,
    output logic [IDW-1:0] hr_id,
    output logic [DW-1:0]  hr_data,
    output logic           hr_err,
    output logic           fr_valid,
    output logic [IDW-1:0] fr_id,
    output logic [DW-1:0]  fr_data,
    output logic           mem_req_valid,
    output logic [AW-1:0]  mem_req_line,
    output logic [BW-1:0]  mem_req_buf,
    input  logic           mem_fill_valid,
    input  logic [BW-1:0]  mem_fill_buf,
    input  logic [DW-1:0]  mem_fill_data,
    input  logic           mem_fill_shared,
    input  logic           snp_valid,
    input  logic [AW-1:0]  snp_addr,
    input  logic           snp_inv,
    output logic           sr_valid,
    output logic           sr_hit,
    output logic           sr_dirty,
    output logic [DW-1:0]  sr_data,
    output logic           wb_valid,
    output logic [AW-1:0]  wb_line,
    output logic [DW-1:0]  wb_data,
    output logic [CW-1:0]  miss_cnt,
    output logic [CW-1:0]  merge_cnt
);
    localparam int IW = $clog2(NL);
    localparam int TW = AW - IW;

    line_st_t       lk_st;
    logic [TW-1:0]  lk_tag;
    logic [DW-1:0]  lk_data;
    fb_st_t         fb_st   [NFB];
    logic [AW-1:0]  fb_line [NFB];
    logic           fb_full [NFB];
    logic [IDW-1:0] fb_head [NFB];
    logic [DW-1:0]  fb_data [NFB];

    logic [IW-1:0] req_idx;
    logic [TW-1:0] req_tag;
    logic          lk_hit, rd_miss, blocked, fill_fire;
    logic [AW-1:0] fill_line;
    logic          m_found, f_found, d_found;
    logic [BW-1:0] m_sel, f_sel, d_sel;
    logic          acc, do_hit, do_merge, do_alloc, wr_ok, do_wr, wr_err;

    assign req_idx = req_addr[IW-1:0];
    assign req_tag = req_addr[AW-1:IW];

    // Hit detection and fill acceptance.
    assign lk_hit    = (lk_st != LN_I) && (lk_tag == req_tag);
    assign fill_fire = mem_fill_valid && (fb_st[mem_fill_buf] == FB_WAIT);
    assign fill_line = fb_line[mem_fill_buf];

    // Buffer search: waiting match, lowest idle, lowest draining.
    always_comb begin
        m_found = 1'b0; m_sel = '0;
        f_found = 1'b0; f_sel = '0;
        d_found = 1'b0; d_sel = '0;
        for (int b = NFB - 1; b >= 0; b--) begin
            if (fb_st[b] == FB_WAIT && fb_line[b] == req_addr) begin
                m_found = 1'b1; m_sel = BW'(b);
            end
            if (fb_st[b] == FB_IDLE) begin
                f_found = 1'b1; f_sel = BW'(b);
            end
            if (fb_st[b] == FB_DRAIN) begin
                d_found = 1'b1; d_sel = BW'(b);
            end
        end
    end

    // Request acceptance and classification.
    assign blocked   = (fill_fire && fill_line[IW-1:0] == req_idx)
                    || (snp_valid && snp_addr[IW-1:0] == req_idx);
    assign rd_miss   = !req_wr && !lk_hit;
    assign req_ready = !blocked && !(rd_miss && (m_found ? fb_full[m_sel] : !f_found));
    assign acc       = req_valid && req_ready;
    assign do_hit    = acc && !req_wr && lk_hit;
    assign do_merge  = acc && rd_miss && m_found;
    assign do_alloc  = acc && rd_miss && !m_found;
    assign wr_ok     = lk_hit && (lk_st == LN_E || lk_st == LN_M);
    assign do_wr     = acc && req_wr && wr_ok;
    assign wr_err    = acc && req_wr && !wr_ok;

    cfc_tag_array #(.NL(NL), .TW(TW), .DW(DW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (req_idx),
        .lk_st      (lk_st),
        .lk_tag     (lk_tag),
        .lk_data    (lk_data),
        .wr_en      (do_wr),
        .wr_idx     (req_idx),
        .wr_data    (req_wdata),
        .snp_en     (snp_valid),
        .snp_idx    (snp_addr[IW-1:0]),
        .snp_tag    (snp_addr[AW-1:IW]),
        .snp_inv    (snp_inv),
        .sr_valid   (sr_valid),
        .sr_hit     (sr_hit),
        .sr_dirty   (sr_dirty),
        .sr_data    (sr_data),
        .ins_en     (fill_fire),
        .ins_idx    (fill_line[IW-1:0]),
        .ins_tag    (fill_line[AW-1:IW]),
        .ins_data   (mem_fill_data),
        .ins_shared (mem_fill_shared),
        .wb_valid   (wb_valid),
        .wb_line    (wb_line),
        .wb_data    (wb_data)
    );

    for (genvar b = 0; b < NFB; b++) begin : g_fb
        cfc_fill_buf #(.LW(AW), .IDW(IDW), .DW(DW), .MQ(MQ)) u_fb (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (do_alloc && f_sel == BW'(b)),
            .alloc_line (req_addr),
            .alloc_id   (req_id),
            .merge      (do_merge && m_sel == BW'(b)),
            .merge_id   (req_id),
            .fill       (fill_fire && mem_fill_buf == BW'(b)),
            .fill_data  (mem_fill_data),
            .pop        (d_found && d_sel == BW'(b)),
            .fb_st      (fb_st[b]),
            .fb_line    (fb_line[b]),
            .full       (fb_full[b]),
            .head_id    (fb_head[b]),
            .fb_data    (fb_data[b])
        );
    end

    // Registered responses, memory request, fill delivery and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hr_valid      <= 1'b0;
            hr_id         <= '0;
            hr_data       <= '0;
            hr_err        <= 1'b0;
            fr_valid      <= 1'b0;
            fr_id         <= '0;
            fr_data       <= '0;
            mem_req_valid <= 1'b0;
            mem_req_line  <= '0;
            mem_req_buf   <= '0;
            miss_cnt      <= '0;
            merge_cnt     <= '0;
        end else begin
            hr_valid      <= do_hit || do_wr || wr_err;
            hr_id         <= req_id;
            hr_data       <= do_hit ? lk_data : (do_wr ? req_wdata : '0);
            hr_err        <= wr_err;
            mem_req_valid <= do_alloc;
            mem_req_line  <= req_addr;
            mem_req_buf   <= f_sel;
            fr_valid      <= d_found;
            fr_id         <= fb_head[d_sel];
            fr_data       <= fb_data[d_sel];
            if (do_alloc) miss_cnt  <= miss_cnt + CW'(1);
            if (do_merge) merge_cnt <= merge_cnt + CW'(1);
        end
    end

    // R8
    stall_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !mem_req_valid);

    // R5
    merge_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_cnt != $past(merge_cnt)) |-> !mem_req_valid);
endmodule

// File: tb/sim_cfc_fill_ctrl.sv
// Directed bench for cfc_fill_ctrl: one task per scenario.
module sim_cfc_fill_ctrl;
    localparam int AW = 8, IDW = 4, DW = 16, CW = 16, BW = 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0, req_wr = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [IDW-1:0] req_id = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           req_ready;
    logic           hr_valid, hr_err, fr_valid, mem_req_valid;
    logic [IDW-1:0] hr_id, fr_id;
    logic [DW-1:0]  hr_data, fr_data, sr_data, wb_data;
    logic [AW-1:0]  mem_req_line, wb_line;
    logic [BW-1:0]  mem_req_buf;
    logic           mem_fill_valid = 1'b0, mem_fill_shared = 1'b0;
    logic [BW-1:0]  mem_fill_buf = '0;
    logic [DW-1:0]  mem_fill_data = '0;
    logic           snp_valid = 1'b0, snp_inv = 1'b0;
    logic [AW-1:0]  snp_addr = '0;
    logic           sr_valid, sr_hit, sr_dirty, wb_valid;
    logic [CW-1:0]  miss_cnt, merge_cnt;

    int n_chk = 0, n_fail = 0;
    logic rdy;

    always #4 clk = ~clk;

    cfc_fill_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
        .req_addr(req_addr), .req_id(req_id), .req_wdata(req_wdata),
        .hr_valid(hr_valid), .hr_id(hr_id), .hr_data(hr_data), .hr_err(hr_err),
        .fr_valid(fr_valid), .fr_id(fr_id), .fr_data(fr_data),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_req_buf(mem_req_buf),
        .mem_fill_valid(mem_fill_valid), .mem_fill_buf(mem_fill_buf),
        .mem_fill_data(mem_fill_data), .mem_fill_shared(mem_fill_shared),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_inv(snp_inv),
        .sr_valid(sr_valid), .sr_hit(sr_hit), .sr_dirty(sr_dirty), .sr_data(sr_data),
        .wb_valid(wb_valid), .wb_line(wb_line), .wb_data(wb_data),
        .miss_cnt(miss_cnt), .merge_cnt(merge_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request for one cycle; registered results visible on return.
    task automatic do_req(input logic wr, input logic [AW-1:0] a,
                          input logic [IDW-1:0] id, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_id = id; req_wdata = wd;
        #1 rdy = req_ready;
        @(posedge clk); #1;
        req_valid = 1'b0; req_wr = 1'b0;
    endtask

    task automatic do_snp(input logic [AW-1:0] a, input logic inv);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = a; snp_inv = inv;
        @(posedge clk); #1;
        snp_valid = 1'b0; snp_inv = 1'b0;
    endtask

    task automatic do_fill(input logic [BW-1:0] b, input logic [DW-1:0] d, input logic sh);
        @(negedge clk);
        mem_fill_valid = 1'b1; mem_fill_buf = b; mem_fill_data = d; mem_fill_shared = sh;
        @(posedge clk); #1;
        mem_fill_valid = 1'b0; mem_fill_shared = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R1 ready", req_ready, 1);
        chk("R1 hr_valid", hr_valid, 0);
        chk("R1 fr_valid", fr_valid, 0);
        chk("R1 mem_req", mem_req_valid, 0);
        chk("R1 sr_valid", sr_valid, 0);
        chk("R1 wb_valid", wb_valid, 0);
        chk("R1 miss_cnt", miss_cnt, 0);
        chk("R1 merge_cnt", merge_cnt, 0);
    endtask

    task automatic t_miss_merge;
        do_req(0, 8'h11, 4'd1, '0);
        chk("R3 ready", rdy, 1);
        chk("R3 mem_req", mem_req_valid, 1);
        chk("R3 line", mem_req_line, 8'h11);
        chk("R3 buf", mem_req_buf, 0);
        chk("R3 miss_cnt", miss_cnt, 1);
        chk("R3 no hit", hr_valid, 0);
        do_req(1, 8'h11, 4'd2, 16'h0005);
        chk("R3 pending write refused", hr_err, 1);
        chk("R10 pending write resp", hr_valid, 1);
        do_snp(8'h11, 0);
        chk("R9 snoop pending valid", sr_valid, 1);
        chk("R3 snoop pending no copy", sr_hit, 0);
        do_req(0, 8'h11, 4'd3, '0);
        chk("R5 no mem req", mem_req_valid, 0);
        chk("R5 merge_cnt", merge_cnt, 1);
        do_req(0, 8'h11, 4'd4, '0);
        chk("R5 merge_cnt 2", merge_cnt, 2);
        do_fill(0, 16'hBEEF, 0);
        chk("R6 not yet", fr_valid, 0);
        idle(1);
        chk("R6 first valid", fr_valid, 1);
        chk("R6 first id", fr_id, 1);
        chk("R6 first data", fr_data, 16'hBEEF);
        idle(1);
        chk("R6 second id", fr_id, 3);
        idle(1);
        chk("R6 third id", fr_id, 4);
        chk("R6 third valid", fr_valid, 1);
        idle(1);
        chk("R6 done", fr_valid, 0);
        do_req(0, 8'h11, 4'd5, '0);
        chk("R2 hit valid", hr_valid, 1);
        chk("R2 hit id", hr_id, 5);
        chk("R4 fill data", hr_data, 16'hBEEF);
        do_req(1, 8'h11, 4'd6, 16'h1234);
        chk("R10 write on E ok", hr_err, 0);
        chk("R10 write data", hr_data, 16'h1234);
        do_snp(8'h11, 0);
        chk("R9 snoop M hit", sr_hit, 1);
        chk("R9 snoop M dirty", sr_dirty, 1);
        chk("R9 snoop M data", sr_data, 16'h1234);
        do_req(1, 8'h11, 4'd6, 16'h9999);
        chk("R10 write on S refused", hr_err, 1);
        do_snp(8'h11, 1);
        chk("R9 inv hit", sr_hit, 1);
        chk("R9 inv clean", sr_dirty, 0);
        do_req(0, 8'h11, 4'd7, '0);
        chk("R9 inv leaves I", mem_req_valid, 1);
        chk("R3 miss_cnt 2", miss_cnt, 2);
        do_fill(0, 16'hCAFE, 1);
        idle(2);
        do_req(1, 8'h11, 4'd7, 16'h1);
        chk("R4 shared fill refuses write", hr_err, 1);
        do_req(0, 8'h11, 4'd7, '0);
        chk("R4 shared fill data", hr_data, 16'hCAFE);
    endtask

    task automatic t_busy;
        do_req(0, 8'h22, 4'd8, '0);
        chk("R3 buf0", mem_req_buf, 0);
        do_req(0, 8'h33, 4'd9, '0);
        chk("R3 buf1", mem_req_buf, 1);
        do_req(0, 8'h11, 4'd14, '0);
        chk("R7 hit during miss", hr_valid, 1);
        chk("R7 hit data", hr_data, 16'hCAFE);
        do_req(0, 8'h44, 4'd13, '0);
        chk("R8 no buffer stall", rdy, 0);
        chk("R8 no mem req", mem_req_valid, 0);
        chk("R8 miss_cnt held", miss_cnt, 4);
        do_req(0, 8'h22, 4'd10, '0);
        do_req(0, 8'h22, 4'd11, '0);
        do_req(0, 8'h22, 4'd12, '0);
        chk("R5 merges", merge_cnt, 5);
        do_req(0, 8'h22, 4'd15, '0);
        chk("R8 full queue stall", rdy, 0);
        chk("R8 merge_cnt held", merge_cnt, 5);
        do_fill(1, 16'h3333, 0);
        idle(2);
        do_req(0, 8'h44, 4'd13, '0);
        chk("R3 reuse buf1", mem_req_buf, 1);
        chk("R3 miss_cnt 5", miss_cnt, 5);
        // back-to-back fills; lower buffer drains first
        @(negedge clk);
        mem_fill_valid = 1'b1; mem_fill_buf = 0; mem_fill_data = 16'h2222;
        @(posedge clk); #1;
        mem_fill_buf = 1; mem_fill_data = 16'h4444;
        @(posedge clk); #1;
        mem_fill_valid = 1'b0;
        chk("R6 order 0", fr_id, 8);
        chk("R6 data b0", fr_data, 16'h2222);
        idle(1); chk("R6 order 1", fr_id, 10);
        idle(1); chk("R6 order 2", fr_id, 11);
        idle(1); chk("R6 order 3", fr_id, 12);
        idle(1); chk("R6 order 4", fr_id, 13);
        chk("R6 data b1", fr_data, 16'h4444);
        idle(1); chk("R6 drained", fr_valid, 0);
    endtask

    task automatic t_collide;
        do_req(0, 8'h05, 4'd1, '0);
        do_fill(0, 16'h5555, 0);
        idle(2);
        do_req(1, 8'h05, 4'd1, 16'hAAAA);
        do_req(0, 8'h0D, 4'd2, '0);
        chk("R3 victim miss", mem_req_valid, 1);
        @(negedge clk);
        mem_fill_valid = 1'b1; mem_fill_buf = 0; mem_fill_data = 16'hDDDD;
        req_valid = 1'b1; req_wr = 1'b0; req_addr = 8'h05; req_id = 4'd3;
        #1 chk("R11 fill blocks index", req_ready, 0);
        @(posedge clk); #1;
        mem_fill_valid = 1'b0; req_valid = 1'b0;
        chk("R11 no response", hr_valid, 0);
        chk("R12 wb valid", wb_valid, 1);
        chk("R12 wb line", wb_line, 8'h05);
        chk("R12 wb data", wb_data, 16'hAAAA);
        idle(2);
        do_req(0, 8'h0D, 4'd4, '0);
        chk("R4 new line hit", hr_data, 16'hDDDD);
        // snoop and fill together, clean victim
        do_req(0, 8'h06, 4'd1, '0);
        do_fill(0, 16'h6666, 0);
        idle(2);
        do_req(0, 8'h0E, 4'd2, '0);
        @(negedge clk);
        mem_fill_valid = 1'b1; mem_fill_buf = 0; mem_fill_data = 16'hEEEE;
        snp_valid = 1'b1; snp_addr = 8'h06; snp_inv = 1'b0;
        @(posedge clk); #1;
        mem_fill_valid = 1'b0; snp_valid = 1'b0;
        chk("R13 old state answered", sr_hit, 1);
        chk("R13 old clean", sr_dirty, 0);
        chk("R12 no wb for clean", wb_valid, 0);
        idle(2);
        do_snp(8'h0E, 0);
        chk("R13 fill resident", sr_hit, 1);
        // snoop takes dirty victim in fill cycle
        do_req(0, 8'h07, 4'd1, '0);
        do_fill(0, 16'h7777, 0);
        idle(2);
        do_req(1, 8'h07, 4'd1, 16'h7A7A);
        do_req(0, 8'h0F, 4'd2, '0);
        @(negedge clk);
        mem_fill_valid = 1'b1; mem_fill_buf = 0; mem_fill_data = 16'hFFFF;
        snp_valid = 1'b1; snp_addr = 8'h07; snp_inv = 1'b1;
        @(posedge clk); #1;
        mem_fill_valid = 1'b0; snp_valid = 1'b0; snp_inv = 1'b0;
        chk("R13 dirty answered", sr_dirty, 1);
        chk("R13 dirty data", sr_data, 16'h7A7A);
        chk("R12 wb suppressed", wb_valid, 0);
        idle(2);
        // snoop blocks same-index request
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = 8'h0F;
        req_valid = 1'b1; req_wr = 1'b0; req_addr = 8'h17; req_id = 4'd5;
        #1 chk("R11 snoop blocks index", req_ready, 0);
        @(posedge clk); #1;
        snp_valid = 1'b0; req_valid = 1'b0;
        chk("R11 no mem req", mem_req_valid, 0);
        chk("R3 miss_cnt final", miss_cnt, 11);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_miss_merge;
        t_busy;
        t_collide;
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule